// File: doc/BRIEF.md
# Ping-Pong Output Address Controller

This block supplies destination addresses to a video write channel that alternates between two output buffer slots. Each slot holds one address for each of three planes (luma, blue-difference and red-difference). Each plane address is split into a low word and a narrow extension word that carries the bits above the low word. Software fills in a slot's six address words and then asks for them to be taken by flipping that slot's load bit in the control word. Flipping the bit in either direction counts as a request. The block spots the flip, copies the slot into shadow storage, and on every frame start hands the next slot's shadow addresses to the write engine. Software can therefore refill the idle slot while the other one is being written.

The block also keeps a sticky status word with write-one-to-clear semantics and a matching interrupt enable word, and drives a single interrupt line from them. The status word records:
- the end of each frame;
- per-plane bus write errors;
- per-plane overflow, meaning a slot was reused without being reloaded;
- per-plane excess overflow, meaning an overflow arrived while the previous one was still pending;
- per-plane panic, meaning the engine's fill level reached a programmable threshold.

Top module: `pingpong_addr_ctrl`

## Requirements
- R1: After reset:
  - the control, status and enable words read as zero;
  - all three output addresses are zero;
  - `out_slot` is 1, so the first frame start selects slot 0;
  - `irq` is low.
- R2: Word index 0 is the control word. Bit 0 is the load request of slot 0 and bit 1 is the load request of slot 1. When a control write changes a load bit, that slot's six address words are copied into its shadow one clock after the write. A control write that leaves a load bit unchanged copies nothing for that slot.
- R3: Each `frame_start` pulse selects the other slot. `out_slot` and the output addresses change on the clock edge that samples the pulse, and they hold their values between pulses.
- R4: Each output address is {extension word, low word} taken from the selected slot's shadow. Low words sit at index 4+4*slot+plane and extension words at index 12+4*slot+plane, with plane 0 = Y, 1 = U and 2 = V.
- R5: If a frame start selects a slot that has not been loaded since it was last selected, status bits 4, 5 and 6 (overflow Y, U, V) are set on that edge.
- R6: If an overflow occurs while its overflow bit is still set, status bits 7, 8 and 9 (excess overflow Y, U, V) are set.
- R7: The status word sits at index 1 and is write-one-to-clear. Each 1 written clears that bit, and bits written as 0 keep their value. A bit that is set in the same cycle as it is cleared stays set.
- R8: `frame_done` sets status bit 0. `wr_err[p]` sets status bit 1+p.
- R9: Control bits [9+2p:8+2p] hold the panic threshold of plane p. Status bit 10+p is set while the threshold is nonzero and the top two bits of the plane's 4-bit fill level are at least the threshold.
- R10: `irq` is high exactly when some status bit is set and its enable bit is also set. The enable word sits at index 2.
- R11: The control word, the enable word and every address word read back on `rd_data` as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Word index of the read |
| rd_data | output | 32 | Read data (combinational) |
| frame_start | input | 1 | Frame start pulse from the write engine |
| frame_done | input | 1 | Frame fully written pulse |
| wr_err | input | 3 | Per-plane bus write error pulses |
| fill_lvl | input | 12 | Per-plane 4-bit fill level, plane 0 in the low nibble |
| out_slot | output | 1 | Slot currently in use |
| out_addr_y | output | 36 | Luma plane destination address |
| out_addr_u | output | 36 | Blue-difference plane destination address |
| out_addr_v | output | 36 | Red-difference plane destination address |
| irq | output | 1 | Interrupt request |

## Verification
A table of frames drives the main function under several load patterns:
- both slots loaded, which gives clean alternation;
- neither slot reloaded, which must raise overflow and keep the stale addresses;
- only the slot about to be used reloaded;
- only the idle slot reloaded.

These patterns separate a design that tracks freshness per slot from one that tracks it globally or swaps the slots. Each row uses different address values with distinct extension nibbles, so swapped planes or a dropped extension show up directly. Directed tests then cover:
- a control write that keeps a load bit unchanged;
- two stale frames in a row, for excess overflow;
- partial status clears;
- the panic threshold compare around its boundary;
- enable-mask gating of the interrupt.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_STAT  = 1;
  localparam int IDX_IEN   = 2;
  localparam int IDX_LOW0  = 4;
  localparam int IDX_EXT0  = 12;
  localparam int SLOT_STEP = 4;
  localparam int NPLANE    = 3;

  localparam int ST_FRM   = 0;
  localparam int ST_WERR  = 1;
  localparam int ST_OVF   = 4;
  localparam int ST_XOVF  = 7;
  localparam int ST_PANIC = 10;
  localparam int NSTAT    = 13;
  localparam int THR_LSB  = 8;

  function automatic int low_index(input int slot, input int plane);
    return IDX_LOW0 + SLOT_STEP * slot + plane;
  endfunction

  function automatic int ext_index(input int slot, input int plane);
    return IDX_EXT0 + SLOT_STEP * slot + plane;
  endfunction

  // panic when threshold nonzero and the level's top bits reach it
  function automatic logic panic_hit(input logic [7:0] lvl_top, input logic [7:0] thr);
    return (thr != 8'd0) && (lvl_top >= thr);
  endfunction
endpackage

// File: rtl/pp_regfile.sv
`timescale 1ns/1ps
module pp_regfile import pp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 4,
  parameter int AW     = 5
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [AW-1:0]                         wr_addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic [AW-1:0]                         rd_addr,
  input  logic [NSTAT-1:0]                      stat_q,
  output logic [DATA_W-1:0]                     rd_data,
  output logic [DATA_W-1:0]                     ctrl_q,
  output logic [NSTAT-1:0]                      ien_q,
  output logic [1:0][NPLANE-1:0][DATA_W-1:0]    low_q,
  output logic [1:0][NPLANE-1:0][EXT_W-1:0]     ext_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      low_q  <= '0;
      ext_q  <= '0;
    end else if (wr_en) begin
      if (int'(wr_addr) == IDX_CTRL) ctrl_q <= wr_data;
      if (int'(wr_addr) == IDX_IEN)  ien_q  <= wr_data[NSTAT-1:0];
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < NPLANE; p++) begin
          if (int'(wr_addr) == low_index(s, p)) low_q[s][p] <= wr_data;
          if (int'(wr_addr) == ext_index(s, p)) ext_q[s][p] <= wr_data[EXT_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) == IDX_CTRL) rd_data = ctrl_q;
    if (int'(rd_addr) == IDX_STAT) rd_data[NSTAT-1:0] = stat_q;
    if (int'(rd_addr) == IDX_IEN)  rd_data[NSTAT-1:0] = ien_q;
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < NPLANE; p++) begin
        if (int'(rd_addr) == low_index(s, p)) rd_data = low_q[s][p];
        if (int'(rd_addr) == ext_index(s, p)) rd_data[EXT_W-1:0] = ext_q[s][p];
      end
    end
  end
endmodule

// File: rtl/pp_slot_seq.sv
`timescale 1ns/1ps
module pp_slot_seq import pp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 4,
  localparam int TOT_W = DATA_W + EXT_W
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         load_bits,
  input  logic [1:0][NPLANE-1:0][DATA_W-1:0] low_q,
  input  logic [1:0][NPLANE-1:0][EXT_W-1:0]  ext_q,
  input  logic                               frame_start,
  output logic [1:0]                         load_hit,
  output logic [1:0]                         fresh_q,
  output logic                               ovf_evt,
  output logic                               cur_slot,
  output logic [NPLANE-1:0][TOT_W-1:0]       out_addr
);
  logic [1:0]                         prev_q;
  logic [1:0][NPLANE-1:0][TOT_W-1:0]  shadow_q;
  logic                               nxt_slot;

  assign load_hit = load_bits ^ prev_q;
  assign nxt_slot = ~cur_slot;
  assign ovf_evt  = frame_start && !fresh_q[nxt_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      shadow_q <= '0;
      fresh_q  <= '0;
      cur_slot <= 1'b1;
      out_addr <= '0;
    end else begin
      prev_q <= load_bits;
      for (int s = 0; s < 2; s++) begin
        if (load_hit[s]) begin
          for (int p = 0; p < NPLANE; p++) shadow_q[s][p] <= {ext_q[s][p], low_q[s][p]};
          fresh_q[s] <= 1'b1;
        end else if (frame_start && (nxt_slot == s[0])) begin
          fresh_q[s] <= 1'b0;
        end
      end
      if (frame_start) begin
        cur_slot <= nxt_slot;
        out_addr <= shadow_q[nxt_slot];
      end
    end
  end
endmodule

// File: rtl/pp_status.sv
`timescale 1ns/1ps
module pp_status import pp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [NPLANE-1:0] wr_err,
  input  logic              ovf_evt,
  input  logic [NPLANE-1:0] panic_vec,
  input  logic [NSTAT-1:0]  clr_vec,
  input  logic [NSTAT-1:0]  ien_q,
  output logic [NSTAT-1:0]  stat_set,
  output logic [NSTAT-1:0]  stat_q,
  output logic              irq
);
  always_comb begin
    stat_set = '0;
    stat_set[ST_FRM] = frame_done;
    for (int p = 0; p < NPLANE; p++) begin
      stat_set[ST_WERR + p]  = wr_err[p];
      stat_set[ST_OVF + p]   = ovf_evt;
      stat_set[ST_XOVF + p]  = ovf_evt && stat_q[ST_OVF + p];
      stat_set[ST_PANIC + p] = panic_vec[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_vec) | stat_set;
  end

  assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/pingpong_addr_ctrl.sv
`timescale 1ns/1ps
module pingpong_addr_ctrl import pp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = 4,
  parameter int AW     = 5,
  parameter int LVL_W  = 4,
  parameter int THR_W  = 2,
  localparam int TOT_W = DATA_W + EXT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    frame_start,
  input  logic                    frame_done,
  input  logic [NPLANE-1:0]       wr_err,
  input  logic [NPLANE*LVL_W-1:0] fill_lvl,
  output logic                    out_slot,
  output logic [TOT_W-1:0]        out_addr_y,
  output logic [TOT_W-1:0]        out_addr_u,
  output logic [TOT_W-1:0]        out_addr_v,
  output logic                    irq
);
  logic [DATA_W-1:0]                  ctrl_q;
  logic [NSTAT-1:0]                   ien_q, stat_q, stat_set, clr_vec;
  logic [1:0][NPLANE-1:0][DATA_W-1:0] low_q;
  logic [1:0][NPLANE-1:0][EXT_W-1:0]  ext_q;
  logic [1:0]                         load_hit, fresh_q;
  logic                               ovf_evt;
  logic [NPLANE-1:0][TOT_W-1:0]       out_addr;
  logic [NPLANE-1:0]                  panic_vec;

  assign clr_vec = (wr_en && int'(wr_addr) == IDX_STAT) ? wr_data[NSTAT-1:0] : '0;

  for (genvar p = 0; p < NPLANE; p++) begin : g_panic
    assign panic_vec[p] = panic_hit(8'(fill_lvl[p*LVL_W + LVL_W-1 -: THR_W]),
                                    8'(ctrl_q[THR_LSB + p*THR_W +: THR_W]));
  end

  pp_regfile #(.DATA_W(DATA_W), .EXT_W(EXT_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .stat_q(stat_q), .rd_data(rd_data), .ctrl_q(ctrl_q),
    .ien_q(ien_q), .low_q(low_q), .ext_q(ext_q));

  pp_slot_seq #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_bits(ctrl_q[1:0]), .low_q(low_q), .ext_q(ext_q),
    .frame_start(frame_start), .load_hit(load_hit), .fresh_q(fresh_q),
    .ovf_evt(ovf_evt), .cur_slot(out_slot), .out_addr(out_addr));

  pp_status u_stat (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .wr_err(wr_err),
    .ovf_evt(ovf_evt), .panic_vec(panic_vec), .clr_vec(clr_vec), .ien_q(ien_q),
    .stat_set(stat_set), .stat_q(stat_q), .irq(irq));

  assign out_addr_y = out_addr[0];
  assign out_addr_u = out_addr[1];
  assign out_addr_v = out_addr[2];
endmodule

// File: rtl/pp_chk.sv
`timescale 1ns/1ps
module pp_chk import pp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int TOT_W  = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [1:0]        load_hit,
  input logic [1:0]        fresh_q,
  input logic              frame_start,
  input logic              frame_done,
  input logic              out_slot,
  input logic [TOT_W-1:0]  out_addr_y,
  input logic [NSTAT-1:0]  stat_q,
  input logic [NSTAT-1:0]  stat_set,
  input logic [NSTAT-1:0]  ien_q,
  input logic              irq
);
  assert_load_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == IDX_CTRL && wr_data[0] != ctrl_q[0]) |=> load_hit[0]);
  assert_slot_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> out_slot != $past(out_slot));
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(out_slot) && $stable(out_addr_y)));
  assert_stale_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fresh_q[~out_slot]) |=> stat_q[ST_OVF]);
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == IDX_STAT && stat_set == '0) |=>
      ((stat_q & $past(wr_data[NSTAT-1:0])) == '0));
  assert_frame_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> stat_q[ST_FRM]);
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind pingpong_addr_ctrl pp_chk #(.DATA_W(DATA_W), .AW(AW), .TOT_W(TOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_q(ctrl_q), .load_hit(load_hit), .fresh_q(fresh_q), .frame_start(frame_start),
  .frame_done(frame_done), .out_slot(out_slot), .out_addr_y(out_addr_y),
  .stat_q(stat_q), .stat_set(stat_set), .ien_q(ien_q), .irq(irq));

// File: tb/pingpong_addr_ctrl_tb.sv
`timescale 1ns/1ps
module pingpong_addr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        frame_start = 1'b0, frame_done = 1'b0;
  logic [2:0]  wr_err = '0;
  logic [11:0] fill_lvl = '0;
  logic        out_slot, irq;
  logic [35:0] out_addr_y, out_addr_u, out_addr_v;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // per-row stimulus: {load slot0, load slot1, base}
  localparam logic [33:0] ROWS [8] = '{
    {1'b1, 1'b1, 32'h1000_0000}, {1'b0, 1'b0, 32'h0},
    {1'b0, 1'b0, 32'h0},         {1'b0, 1'b1, 32'h2222_0003},
    {1'b1, 1'b0, 32'h3333_0005}, {1'b0, 1'b0, 32'h0},
    {1'b1, 1'b1, 32'h4444_0007}, {1'b0, 1'b1, 32'h5555_0009}};

  logic [35:0] sh [2][3];
  logic [35:0] staged [2][3];
  bit          fresh_m [2];
  logic        cur_m = 1'b1;
  logic [31:0] ctrl_m = '0;

  always #2.5 clk = ~clk;

  pingpong_addr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start),
    .frame_done(frame_done), .wr_err(wr_err), .fill_lvl(fill_lvl),
    .out_slot(out_slot), .out_addr_y(out_addr_y), .out_addr_u(out_addr_u),
    .out_addr_v(out_addr_v), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = 5'(a);
    #0.5;
    d = rd_data;
  endtask

  task automatic program_slot(input int s, input logic [31:0] base);
    for (int p = 0; p < 3; p++) begin
      logic [31:0] lo;
      logic [3:0]  ex;
      lo = base + 32'(s * 'h100) + 32'(p * 'h10);
      ex = base[3:0] + 4'(s) + 4'(p);
      wr(4 + 4 * s + p, lo);
      wr(12 + 4 * s + p, {28'h0, ex});
      staged[s][p] = {ex, lo};
    end
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic frame_checked(input string tag, output bit exp_ovf);
    logic nxt;
    nxt = ~cur_m;
    frame();
    exp_ovf = !fresh_m[nxt];
    fresh_m[nxt] = 1'b0;
    cur_m = nxt;
    chk(out_slot == nxt, {tag, " R3 slot"}, 64'(out_slot), 64'(nxt));
    chk(out_addr_y == sh[nxt][0] && out_addr_u == sh[nxt][1] && out_addr_v == sh[nxt][2],
        {tag, " R4 addr"}, {28'h0, out_addr_u}, {28'h0, sh[nxt][1]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit          ov;
    for (int s = 0; s < 2; s++) begin
      fresh_m[s] = 1'b0;
      for (int p = 0; p < 3; p++) begin
        sh[s][p] = '0;
        staged[s][p] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1, d); chk(d == 0, "R1 status", 64'(d), 0);
    rd(0, d); chk(d == 0, "R1 control", 64'(d), 0);
    rd(2, d); chk(d == 0, "R1 enable", 64'(d), 0);
    chk(out_slot == 1'b1 && irq == 1'b0, "R1 slot/irq", {out_slot, irq}, 2'b10);
    chk(out_addr_y == 0 && out_addr_u == 0 && out_addr_v == 0, "R1 addr", 64'(out_addr_v), 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 8; i++) begin
      logic [33:0] row;
      logic [31:0] st;
      row = ROWS[i];
      for (int s = 0; s < 2; s++) begin
        if (row[33 - s]) begin
          program_slot(s, row[31:0]);
          ctrl_m[s] = ~ctrl_m[s];
          for (int p = 0; p < 3; p++) sh[s][p] = staged[s][p];
          fresh_m[s] = 1'b1;
        end
      end
      wr(0, ctrl_m);
      frame_checked($sformatf("row%0d", i), ov);
      rd(1, st);
      chk(st[9:4] == (ov ? 6'b000111 : 6'b000000), $sformatf("row%0d R5 overflow", i),
          64'(st[9:4]), ov ? 64'h7 : 64'h0);
      wr(1, 32'hFFFF_FFFF);
    end

    // R2: control write that keeps load bits unchanged copies nothing
    program_slot(0, 32'h7777_000B);
    wr(0, ctrl_m);
    frame_checked("noflip R2", ov);
    chk(ov == 1'b1, "R2 noflip stale", 64'(ov), 1);
    // R6: second stale frame while overflow still pending
    frame_checked("excess", ov);
    rd(1, d);
    chk(d[9:4] == 6'b111111, "R6 excess overflow", 64'(d[9:4]), 64'h3F);
    // R7 partial clear
    wr(1, 32'h0000_0010);
    rd(1, d);
    chk(d[9:4] == 6'b111110, "R7 partial clear", 64'(d[9:4]), 64'h3E);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d);
    chk(d == 0, "R7 clear all", 64'(d), 0);

    // R8 frame done and write errors
    @(negedge clk);
    frame_done = 1'b1; wr_err = 3'b101;
    @(negedge clk);
    frame_done = 1'b0; wr_err = 3'b000;
    rd(1, d);
    chk(d[3:0] == 4'b1011, "R8 done/err", 64'(d[3:0]), 64'hB);

    // R10 interrupt mask
    chk(irq == 1'b0, "R10 masked", 64'(irq), 0);
    wr(2, 32'h0000_0004);
    chk(irq == 1'b0, "R10 unset bit enabled", 64'(irq), 0);
    wr(2, 32'h0000_0008);
    chk(irq == 1'b1, "R10 set bit enabled", 64'(irq), 1);
    wr(1, 32'hFFFF_FFFF);
    chk(irq == 1'b0, "R10 cleared", 64'(irq), 0);

    // R9 panic threshold: Y threshold 2, Y level 8 (top bits 2), U level 15 with threshold 0
    fill_lvl = 12'h0F8;
    ctrl_m[9:8] = 2'd2;
    wr(0, ctrl_m);
    @(negedge clk);
    rd(1, d);
    chk(d[12:10] == 3'b001, "R9 panic at threshold", 64'(d[12:10]), 1);
    fill_lvl = 12'h0F4;
    wr(1, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(1, d);
    chk(d[12:10] == 3'b000, "R9 below threshold", 64'(d[12:10]), 0);

    // R11 readback
    rd(0, d); chk(d == ctrl_m, "R11 control", 64'(d), 64'(ctrl_m));
    rd(2, d); chk(d == 32'h8, "R11 enable", 64'(d), 8);
    rd(4, d); chk(d == staged[0][0][31:0], "R11 low word", 64'(d), 64'(staged[0][0][31:0]));
    rd(14, d); chk(d == {28'h0, staged[0][2][35:32]}, "R11 ext word", 64'(d), 64'(staged[0][2][35:32]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule